// File: doc/BRIEF.md
# Shared DRAM Nibble Access Sequencer

This block shares one DRAM, four bits wide and with multiplexed row and column addresses, between a display fetch engine and a CPU. Time is cut into slots of eight phases. An eight-bit one-hot ring marks the phase. In each slot the block puts out a row address and then two column addresses that differ only in their lowest bit. It reads one nibble at each column and joins the two nibbles into one byte. Who owns a slot is decided in its first phase. The display takes the slot when its fetch conditions hold. Otherwise the slot goes to the CPU, which gets the byte back if it asked for a read.

The block also keeps the display address pointer for a screen laid out in character cells. Consecutive bytes on one pixel line sit eight addresses apart. Each new pixel line inside a cell starts one address above the previous line start. Leaving the last line of a cell moves the pointer back by seven. The screen region always ends just below 0x8000. Any address that reaches 0x8000 is folded back by subtracting the effective screen size. The surrounding timing logic supplies the frame start, line advance, window and blank-line flags, and the fetch interval for the current mode.

Top module: `nibble_dram_seq`

## Requirements
- R1: `phase_o` is one-hot. It holds phase 0 (bit 0) in the first cycle after reset and moves one bit up every cycle, returning from bit 7 to bit 0.
- R2: `dram_addr` shows the row, slot address bits 15..7, in phase 1, where `row_latch` is high. In phases 2 to 4 it shows the column `{addr[6:0],0}`, with `col_latch` high in phase 2. In phases 5 to 7 it shows the column `{addr[6:0],1}`, with `col_latch` high in phase 5. `bank_release` is high in phase 7.
- R3: `dram_dq` sampled in phase 3 becomes bits 7..4 of the byte. `dram_dq` sampled in phase 6 becomes bits 3..0. The byte appears with a one-cycle valid pulse in phase 7 of the same slot.
- R4: A slot is a display slot only if, in its phase 0, `nmi` is low, the fetch-interval counter is zero, `in_window` is high and `blank_line` is low. A display slot fetches from the display pointer and raises `disp_valid`. Any other slot uses `cpu_addr` as sampled in phase 0.
- R5: A CPU slot whose `cpu_rd` was high in phase 0 raises `cpu_valid` with the byte in `cpu_data`. Slots with `cpu_rd` low and display slots never raise `cpu_valid`. `disp_valid` and `cpu_valid` are never high together.
- R6: The fetch-interval counter is zero after reset. It advances at the end of every slot and returns to zero when it would reach `fetch_ivl`. With `fetch_ivl` = 1 every eligible slot can fetch, and with 2 every other slot.
- R7: Each display byte advances the pointer by 8. A result of 0x8000 or more is reduced by the effective screen size, defined as 0x8000 minus the screen start.
- R8: `frame_start` loads both the pointer and the line start with the screen start, which is 0x8000 minus `scr_size` with bits 7..0 cleared. It also zeroes the line-in-cell counter, and it overrides a byte advance in the same cycle.
- R9: On `line_adv`, on lines 1 to 7 of a cell the pointer becomes line start + 1. On the eighth line the pointer moves down by 7 from its current value. Both results are folded as in R7 and become the new line start.
- R10: When `line_adv` and a display byte advance fall in the same cycle, the line rule of R9 is applied first and the advance of 8 (with folding) is then applied on top of it.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| cpu_addr | input | 16 | CPU byte address, sampled in phase 0 |
| cpu_rd | input | 1 | CPU read request, sampled in phase 0 |
| nmi | input | 1 | Non-maskable interrupt active; blocks display slots |
| in_window | input | 1 | Beam position lies in the pixel window |
| blank_line | input | 1 | Current line is a blank spacer line |
| fetch_ivl | input | 7 | Slots between display fetches for the mode |
| scr_size | input | 16 | Nominal screen size in bytes |
| frame_start | input | 1 | Reload the pointer at the top of the frame |
| line_adv | input | 1 | End of a pixel line |
| dram_dq | input | 4 | Nibble read from the DRAM |
| dram_addr | output | 9 | Multiplexed row or column address |
| row_latch | output | 1 | Row address latch strobe |
| col_latch | output | 1 | Column address latch strobe |
| bank_release | output | 1 | Row and column deselect |
| phase_o | output | 8 | One-hot slot phase |
| disp_ptr | output | 16 | Display address pointer |
| disp_byte | output | 8 | Fetched display byte |
| disp_valid | output | 1 | Display byte valid pulse |
| cpu_data | output | 8 | Byte returned to the CPU |
| cpu_valid | output | 1 | CPU read data valid pulse |

## Verification
The pointer can be hit in a single cycle by both a line step and the +8 advance of a display byte finishing in phase 6. A frame reload can also land on top of that advance. The bench raises `line_adv` often in cycles where `phase_o` shows phase 6, and sometimes at random elsewhere. It compares `disp_ptr` in the next cycle with an arithmetic model that applies the line rule and then the +8. Small screen sizes are included in the sweep so that folding at 0x8000 occurs many times, including inside these combined updates.

// File: rtl/nds_pkg.sv
package nds_pkg;
  localparam int ADDR_W   = 16;
  localparam int NIB_W    = 4;
  localparam int BYTE_W   = 2 * NIB_W;
  localparam int COL_BITS = 7;
  localparam int RA_W     = ADDR_W - COL_BITS;
  localparam int PHASES   = 8;
  localparam int PAGE_LSB = 8;

  typedef logic [ADDR_W-1:0] addr_t;
  typedef logic [RA_W-1:0]   ra_t;
  typedef logic [NIB_W-1:0]  nib_t;
  typedef logic [BYTE_W-1:0] byte_t;

  localparam addr_t SCR_LIMIT = addr_t'(1) << (ADDR_W - 1);

  function automatic ra_t row_of(input addr_t a);
    return a[ADDR_W-1:COL_BITS];
  endfunction

  function automatic ra_t col_of(input addr_t a, input logic nib_sel);
    return ra_t'({a[COL_BITS-1:0], nib_sel});
  endfunction

  function automatic addr_t scr_start(input addr_t size);
    addr_t d;
    d = SCR_LIMIT - size;
    return {d[ADDR_W-1:PAGE_LSB], {PAGE_LSB{1'b0}}};
  endfunction

  function automatic addr_t fold(input addr_t a, input addr_t eff);
    return (a >= SCR_LIMIT) ? (a - eff) : a;
  endfunction
endpackage

// File: rtl/nds_phase_ring.sv
module nds_phase_ring #(
  parameter int N = 8
) (
  input  logic         clk,
  input  logic         rst_n,
  output logic [N-1:0] phase
);
  logic [N-1:0] nxt;

  generate
    for (genvar i = 0; i < N; i++) begin : g_bit
      if (i == 0) begin : g_head
        assign nxt[i] = phase[N-1];
      end else begin : g_body
        assign nxt[i] = phase[i-1];
      end
    end
  endgenerate

  always_ff @(posedge clk) begin
    if (!rst_n) phase <= N'(1);
    else        phase <= nxt;
  end
endmodule

// File: rtl/nds_fetch_pace.sv
module nds_fetch_pace #(
  parameter int IVL_W = 7
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             slot_end,
  input  logic [IVL_W-1:0] ivl,
  output logic             pace_zero
);
  logic [IVL_W-1:0] cnt;
  logic [IVL_W:0]   nxt;

  assign nxt       = {1'b0, cnt} + 1'b1;
  assign pace_zero = (cnt == '0);

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      cnt <= '0;
    end else if (slot_end) begin
      if (nxt >= {1'b0, ivl}) cnt <= '0;
      else                    cnt <= nxt[IVL_W-1:0];
    end
  end
endmodule

// File: rtl/nds_disp_ptr.sv
module nds_disp_ptr
  import nds_pkg::*;
#(
  parameter int LINES = 8,
  parameter int STEP  = 8
) (
  input  logic  clk,
  input  logic  rst_n,
  input  addr_t scr_size,
  input  logic  frame_start,
  input  logic  line_adv,
  input  logic  byte_done,
  output addr_t ptr
);
  localparam int LW = $clog2(LINES);

  logic [LW-1:0] line_idx;
  addr_t         line_start;
  addr_t         start_w, eff_w, line_pos, base_w, stepped_w;
  logic          cell_end;

  assign start_w   = scr_start(scr_size);
  assign eff_w     = SCR_LIMIT - start_w;
  assign cell_end  = (line_idx == LW'(LINES - 1));
  assign line_pos  = cell_end ? fold(ptr - addr_t'(LINES - 1), eff_w)
                              : fold(line_start + addr_t'(1), eff_w);
  assign base_w    = line_adv ? line_pos : ptr;
  assign stepped_w = byte_done ? fold(base_w + addr_t'(STEP), eff_w) : base_w;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      ptr        <= '0;
      line_start <= '0;
      line_idx   <= '0;
    end else if (frame_start) begin
      ptr        <= start_w;
      line_start <= start_w;
      line_idx   <= '0;
    end else begin
      ptr <= stepped_w;
      if (line_adv) begin
        line_start <= line_pos;
        line_idx   <= line_idx + 1'b1;
      end
    end
  end
endmodule

// File: rtl/nds_slot_engine.sv
module nds_slot_engine
  import nds_pkg::*;
(
  input  logic              clk,
  input  logic              rst_n,
  input  logic [PHASES-1:0] phase,
  input  logic              grant_now,
  input  addr_t             ptr,
  input  addr_t             cpu_addr,
  input  logic              cpu_rd,
  input  nib_t              dq,
  output ra_t               dram_addr,
  output logic              row_latch,
  output logic              col_latch,
  output logic              bank_release,
  output byte_t             disp_byte,
  output logic              disp_valid,
  output byte_t             cpu_data,
  output logic              cpu_valid,
  output logic              byte_done
);
  logic  owner_q, srd_q;
  addr_t saddr_q, pick_w;
  nib_t  hi_q;

  assign pick_w       = grant_now ? ptr : cpu_addr;
  assign row_latch    = phase[1];
  assign col_latch    = phase[2] | phase[5];
  assign bank_release = phase[7];
  assign byte_done    = phase[6] & owner_q;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      owner_q    <= 1'b0;
      srd_q      <= 1'b0;
      saddr_q    <= '0;
      dram_addr  <= '0;
      hi_q       <= '0;
      disp_byte  <= '0;
      disp_valid <= 1'b0;
      cpu_data   <= '0;
      cpu_valid  <= 1'b0;
    end else begin
      disp_valid <= 1'b0;
      cpu_valid  <= 1'b0;
      if (phase[0]) begin
        owner_q   <= grant_now;
        srd_q     <= cpu_rd;
        saddr_q   <= pick_w;
        dram_addr <= row_of(pick_w);
      end
      if (phase[1]) dram_addr <= col_of(saddr_q, 1'b0);
      if (phase[3]) hi_q <= dq;
      if (phase[4]) dram_addr <= col_of(saddr_q, 1'b1);
      if (phase[6]) begin
        if (owner_q) begin
          disp_byte  <= {hi_q, dq};
          disp_valid <= 1'b1;
        end else if (srd_q) begin
          cpu_data  <= {hi_q, dq};
          cpu_valid <= 1'b1;
        end
      end
    end
  end
endmodule

// File: rtl/nibble_dram_seq.sv
module nibble_dram_seq
  import nds_pkg::*;
#(
  parameter int IVL_W = 7,
  parameter int LINES = 8,
  parameter int STEP  = 8
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic [ADDR_W-1:0] cpu_addr,
  input  logic              cpu_rd,
  input  logic              nmi,
  input  logic              in_window,
  input  logic              blank_line,
  input  logic [IVL_W-1:0]  fetch_ivl,
  input  logic [ADDR_W-1:0] scr_size,
  input  logic              frame_start,
  input  logic              line_adv,
  input  logic [NIB_W-1:0]  dram_dq,
  output logic [RA_W-1:0]   dram_addr,
  output logic              row_latch,
  output logic              col_latch,
  output logic              bank_release,
  output logic [PHASES-1:0] phase_o,
  output logic [ADDR_W-1:0] disp_ptr,
  output logic [BYTE_W-1:0] disp_byte,
  output logic              disp_valid,
  output logic [BYTE_W-1:0] cpu_data,
  output logic              cpu_valid
);
  logic pace_zero, grant_now, byte_done, slot_end;

  assign slot_end  = phase_o[PHASES-1];
  assign grant_now = !nmi && pace_zero && in_window && !blank_line;

  nds_phase_ring #(.N(PHASES)) ring_i (
    .clk(clk), .rst_n(rst_n), .phase(phase_o)
  );

  nds_fetch_pace #(.IVL_W(IVL_W)) pace_i (
    .clk(clk), .rst_n(rst_n), .slot_end(slot_end),
    .ivl(fetch_ivl), .pace_zero(pace_zero)
  );

  nds_disp_ptr #(.LINES(LINES), .STEP(STEP)) ptr_i (
    .clk(clk), .rst_n(rst_n), .scr_size(scr_size),
    .frame_start(frame_start), .line_adv(line_adv),
    .byte_done(byte_done), .ptr(disp_ptr)
  );

  nds_slot_engine eng_i (
    .clk(clk), .rst_n(rst_n), .phase(phase_o), .grant_now(grant_now),
    .ptr(disp_ptr), .cpu_addr(cpu_addr), .cpu_rd(cpu_rd), .dq(dram_dq),
    .dram_addr(dram_addr), .row_latch(row_latch), .col_latch(col_latch),
    .bank_release(bank_release), .disp_byte(disp_byte),
    .disp_valid(disp_valid), .cpu_data(cpu_data), .cpu_valid(cpu_valid),
    .byte_done(byte_done)
  );
endmodule

// File: rtl/nibble_dram_seq_chk.sv
module nibble_dram_seq_chk
  import nds_pkg::*;
(
  input logic              clk,
  input logic              rst_n,
  input logic [PHASES-1:0] phase_o,
  input logic [RA_W-1:0]   dram_addr,
  input logic              disp_valid,
  input logic              cpu_valid,
  input logic              nmi,
  input logic              frame_start,
  input logic              line_adv,
  input logic [ADDR_W-1:0] disp_ptr
);
  AST_RING_ONEHOT: assert property (@(posedge clk) disable iff (!rst_n)
    $countones(phase_o) == 1); // R1
  AST_RING_WRAP: assert property (@(posedge clk) disable iff (!rst_n)
    phase_o[7] |=> phase_o[0]); // R1
  AST_COL0_HELD: assert property (@(posedge clk) disable iff (!rst_n)
    phase_o[3] |-> $stable(dram_addr)); // R2
  AST_COL1_HELD: assert property (@(posedge clk) disable iff (!rst_n)
    phase_o[6] |-> $stable(dram_addr)); // R2
  AST_VALID_IN_P7: assert property (@(posedge clk) disable iff (!rst_n)
    (disp_valid || cpu_valid) |-> phase_o[7]); // R3
  AST_SINGLE_OWNER: assert property (@(posedge clk) disable iff (!rst_n)
    !(disp_valid && cpu_valid)); // R5
  AST_NMI_BLOCKS: assert property (@(posedge clk) disable iff (!rst_n)
    (phase_o[0] && nmi) |-> ##7 !disp_valid); // R4
  AST_PTR_QUIET: assert property (@(posedge clk) disable iff (!rst_n)
    (!$past(frame_start) && !$past(line_adv) && !disp_valid) |-> $stable(disp_ptr)); // R7
endmodule

bind nibble_dram_seq nibble_dram_seq_chk chk_i (
  .clk(clk), .rst_n(rst_n), .phase_o(phase_o), .dram_addr(dram_addr),
  .disp_valid(disp_valid), .cpu_valid(cpu_valid), .nmi(nmi),
  .frame_start(frame_start), .line_adv(line_adv), .disp_ptr(disp_ptr)
);

// File: tb/nibble_dram_seq_tb.sv
module nibble_dram_seq_tb_top;
  logic        clk = 1'b0;
  logic        rst_n;
  logic [15:0] cpu_addr;
  logic        cpu_rd, nmi, in_window, blank_line;
  logic [6:0]  fetch_ivl;
  logic [15:0] scr_size;
  logic        frame_start, line_adv;
  logic [3:0]  dram_dq;
  logic [8:0]  dram_addr;
  logic        row_latch, col_latch, bank_release;
  logic [7:0]  phase_o;
  logic [15:0] disp_ptr;
  logic [7:0]  disp_byte, cpu_data;
  logic        disp_valid, cpu_valid;

  int total = 0;
  int bad   = 0;
  bit done  = 0;

  always #5 clk = ~clk;

  nibble_dram_seq dut_i (
    .clk(clk), .rst_n(rst_n), .cpu_addr(cpu_addr), .cpu_rd(cpu_rd),
    .nmi(nmi), .in_window(in_window), .blank_line(blank_line),
    .fetch_ivl(fetch_ivl), .scr_size(scr_size), .frame_start(frame_start),
    .line_adv(line_adv), .dram_dq(dram_dq), .dram_addr(dram_addr),
    .row_latch(row_latch), .col_latch(col_latch), .bank_release(bank_release),
    .phase_o(phase_o), .disp_ptr(disp_ptr), .disp_byte(disp_byte),
    .disp_valid(disp_valid), .cpu_data(cpu_data), .cpu_valid(cpu_valid)
  );

  // DRAM content: a nibble computed from the latched row and column
  function automatic logic [3:0] nib(input logic [8:0] r, input logic [8:0] c);
    logic [15:0] s;
    s = {7'd0, r} * 16'd5 + {7'd0, c} * 16'd11 + {10'd0, c[8:3]};
    return s[3:0];
  endfunction

  logic [8:0] rowq = '0, colq = '0;
  assign dram_dq = nib(rowq, colq);

  function automatic logic [7:0] byte_at(input logic [15:0] a);
    return {nib(a[15:7], {2'b00, a[6:0]} << 1), nib(a[15:7], ({2'b00, a[6:0]} << 1) | 9'd1)};
  endfunction

  function automatic logic [15:0] start_of(input logic [15:0] sz);
    return (16'h8000 - sz) & 16'hFF00;
  endfunction

  function automatic logic [15:0] wrap16(input logic [15:0] a, input logic [15:0] sz);
    if (a < 16'h8000) return a;
    return a - (16'h8000 - start_of(sz));
  endfunction

  task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
    total++;
    if (act !== exp) begin
      bad++;
      $display("FAIL %s act=%0h exp=%0h t=%0t", tag, act, exp, $time);
    end
  endtask

  // bench model state
  int          m_phase, m_pace, m_line;
  logic [15:0] m_ptr, m_ls, m_saddr;
  bit          m_grant, m_srd;
  string       m_tag;

  always @(negedge clk) begin
    if (!rst_n) begin
      m_phase = 0; m_pace = 0; m_line = 0;
      m_ptr = '0; m_ls = '0; m_saddr = '0;
      m_grant = 0; m_srd = 0; m_tag = "R1 reset";
    end else if (!done) begin
      logic [15:0] p;
      logic [15:0] st;
      bit bstep;
      chk("R1 phase", {24'd0, phase_o}, 32'd1 << m_phase);
      chk(m_tag, {16'd0, disp_ptr}, {16'd0, m_ptr});
      if (m_phase == 1) begin
        chk("R2 row", {23'd0, dram_addr}, {23'd0, m_saddr[15:7]});
        chk("R2 row strobe", {31'd0, row_latch}, 32'd1);
      end
      if (m_phase == 2) chk("R2 col0", {23'd0, dram_addr}, {24'd0, m_saddr[6:0], 1'b0});
      if (m_phase == 5) chk("R2 col1", {23'd0, dram_addr}, {24'd0, m_saddr[6:0], 1'b1});
      if (m_phase == 7) begin
        chk("R4 R6 disp grant", {31'd0, disp_valid}, {31'd0, m_grant});
        chk("R5 cpu valid", {31'd0, cpu_valid}, {31'd0, !m_grant && m_srd});
        if (m_grant) chk("R3 disp byte", {24'd0, disp_byte}, {24'd0, byte_at(m_saddr)});
        if (!m_grant && m_srd) chk("R5 cpu byte", {24'd0, cpu_data}, {24'd0, byte_at(m_saddr)});
      end else if (disp_valid || cpu_valid) begin
        chk("R3 pulse outside phase 7", {30'd0, disp_valid, cpu_valid}, 32'd0);
      end
      if (row_latch) rowq = dram_addr;
      if (col_latch) colq = dram_addr;
      // advance model across the coming edge
      if (m_phase == 0) begin
        m_grant = !nmi && (m_pace == 0) && in_window && !blank_line;
        m_saddr = m_grant ? m_ptr : cpu_addr;
        m_srd   = cpu_rd;
      end
      bstep = (m_phase == 6) && m_grant;
      st = start_of(scr_size);
      if (frame_start) begin
        m_ptr = st; m_ls = st; m_line = 0;
        m_tag = bstep ? "R10 frame" : "R8";
      end else begin
        p = m_ptr;
        if (line_adv) begin
          m_line = (m_line + 1) % 8;
          p = (m_line != 0) ? wrap16(m_ls + 16'd1, scr_size) : wrap16(p - 16'd7, scr_size);
          m_ls = p;
        end
        if (bstep) p = wrap16(p + 16'd8, scr_size);
        m_ptr = p;
        if (line_adv && bstep) m_tag = "R10";
        else if (line_adv)     m_tag = "R9";
        else                   m_tag = "R7";
      end
      if (m_phase == 7) m_pace = (m_pace + 1 >= int'(fetch_ivl)) ? 0 : m_pace + 1;
      m_phase = (m_phase + 1) % 8;
    end
  end

  logic [31:0] r = 32'h1234_5679;
  function automatic logic [31:0] xs(input logic [31:0] v);
    logic [31:0] t;
    t = v ^ (v << 13);
    t = t ^ (t >> 17);
    return t ^ (t << 5);
  endfunction

  task automatic run_cfg(input logic [6:0] ivl, input logic [15:0] sz, input int n);
    fetch_ivl = ivl; scr_size = sz; frame_start = 1'b1; line_adv = 1'b0;
    @(posedge clk); #2;
    frame_start = 1'b0;
    for (int i = 0; i < n; i++) begin
      r = xs(r);
      nmi         = (r[3:0] == 4'd0);
      in_window   = (r[5:4] != 2'd0);
      blank_line  = (r[8:6] == 3'd0);
      cpu_rd      = r[9];
      cpu_addr    = {r[31:22], r[15:10]};
      line_adv    = (r[21:15] == 7'd0) || (phase_o[6] && r[18:16] == 3'd0);
      frame_start = ((i % 7000) == 6999) || (phase_o[6] && r[27:20] == 8'd0);
      @(posedge clk); #2;
    end
    line_adv = 1'b0; frame_start = 1'b0;
  endtask

  initial begin
    rst_n = 1'b0; cpu_addr = '0; cpu_rd = 1'b0; nmi = 1'b0; in_window = 1'b0;
    blank_line = 1'b0; fetch_ivl = 7'd1; scr_size = 16'h0100;
    frame_start = 1'b0; line_adv = 1'b0;
    repeat (4) @(posedge clk);
    #2 rst_n = 1'b1;
    @(negedge clk); #1;
    chk("R1 reset phase", {24'd0, phase_o}, 32'd1);
    chk("R6 reset valids", {30'd0, disp_valid, cpu_valid}, 32'd0);
    @(posedge clk); #2;
    run_cfg(7'd1, 16'h0100, 20000);
    run_cfg(7'd2, 16'h1F40, 20000);
    run_cfg(7'd4, 16'h5000, 20000);
    run_cfg(7'd1, 16'h0300, 20000);
    @(negedge clk);
    done = 1;
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

  initial begin
    repeat (190000) @(posedge clk);
    if (!done) begin
      done = 1;
      total++; bad++;
      $display("FAIL watchdog R1 act=running exp=finished");
      $display("test done: total=%0d bad=%0d", total, bad);
      $finish;
    end
  end
endmodule